// File: doc/BRIEF.md
# Gated LFSR Signature Analyzer

This debug block condenses a serial bit stream into a 16-bit signature. It watches four asynchronous probe lines: a start marker, a stop marker, a probe clock and a data line. All four are brought into the system clock domain. Each active edge of the probe clock is turned into a one-cycle strobe, and on that strobe the start, stop and data lines are sampled together.

A measurement window opens on the selected edge of the start marker and closes on the selected edge of the stop marker. While the window is open, every sampled data bit enters a right-shifting feedback register. When the window closes, the register contents are presented as the signature and the register returns to zero.

The signature is given both as a raw 16-bit word and as four ASCII display characters. Each character is taken from a 16-symbol alphabet that is not hexadecimal, so the value can be compared by eye with signatures recorded on known-good hardware.

Top module: `sig_window_analyzer`

## Requirements
- R1: Start, stop and data are sampled only on the active edge of the probe clock (falling by default, parameter CLK_FALL=1). The opposite edge has no effect, even if the stop line pulses around it.
- R2: While the window is closed, a sampled start value that differs from the previous start sample and equals the active level (1 for the default rising polarity) opens the window.
- R3: The stop line is examined only when the start-opening rule did not apply and the window is open. A stop change while the window is closed never produces a signature.
- R4: While the window is open, a sampled stop value that differs from the previous stop sample and equals the active level (1 by default) closes the window. No data bit is shifted on that probe clock.
- R5: Each shift moves the register right by one bit. The new bit 15 is the XOR of the sampled data with register bits 0, 4, 7 and 9 (mask 0x0291).
- R6: The data bit sampled on the probe clock that opens the window is already shifted in. Starting from zero with data 1, the register then holds 0x8000.
- R7: On closing, the register value is reported as sig_value and the register is cleared, so the next window starts from zero.
- R8: sig_chars[8k+7:8k] encodes nibble k of sig_value, with nibble 0 in the low byte. The nibble is bit-reversed and used as an index into the ASCII sequence 0,1,2,3,4,5,6,7,8,9,A,C,F,H,P,U. For example, nibble 0x8 gives "1" and nibble 0x5 gives "A".
- R9: After reset, the stored previous start and stop samples hold the inactive level (0 for rising polarity). With the defaults, a start value of 1 on the first probe clock therefore opens the window.
- R10: sig_valid is high for exactly one system clock per closed window, while sig_value and sig_chars hold the signature.
- R11: The synchronous reset rst closes the window, clears the register and returns both previous samples to their inactive levels. A stop edge arriving after reset then yields no signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| probe_start | input | 1 | Asynchronous start marker |
| probe_stop | input | 1 | Asynchronous stop marker |
| probe_clk | input | 1 | Asynchronous probe clock |
| probe_data | input | 1 | Asynchronous serial data |
| sig_valid | output | 1 | One-cycle pulse when a signature is ready |
| sig_value | output | 16 | Signature word |
| sig_chars | output | 32 | Four ASCII symbols, nibble 0 in bits 7:0 |

## Verification
Some properties are checked by assertions on every cycle. These are: the register stays zero while the window is closed, a valid pulse coincides with a cleared register and a closed window, each shift in an open window moves the old bits down by one place, reset leaves the state empty, and every reported character belongs to the alphabet. The bench scenarios cover what needs the sampling history: opening and closing priority, the first-clock edge after reset, the opposite probe edge being ignored, and whether the signature value is correct for a given data sequence. These are checked against a bench model driven by random and directed probe sequences.

// File: rtl/sig_pkg.sv
package sig_pkg;
    localparam int SIG_W = 16;
    localparam int NIB_N = SIG_W / 4;
    localparam int CHR_W = 8 * NIB_N;

    typedef struct packed {
        logic start;
        logic stop;
        logic data;
    } probe_smp_t;

    // Display symbol for an already bit-reversed nibble index.
    function automatic logic [7:0] sym_of(input logic [3:0] idx);
        logic [7:0] c;
        case (idx)
            4'd10:   c = 8'h41; // A
            4'd11:   c = 8'h43; // C
            4'd12:   c = 8'h46; // F
            4'd13:   c = 8'h48; // H
            4'd14:   c = 8'h50; // P
            4'd15:   c = 8'h55; // U
            default: c = 8'h30 + {4'd0, idx};
        endcase
        return c;
    endfunction
endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk) begin
        stg_q <= {stg_q[STAGES-2:0], din};
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/sig_edge_strobe.sv
module sig_edge_strobe #(
    parameter bit ACT_FALL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic strobe
);
    localparam logic ACT_LVL = ~ACT_FALL;

    typedef struct packed {
        logic armed;
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.armed = 1'b1;
        st_d.prev  = lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign strobe = st_q.armed && (lvl != st_q.prev) && (lvl == ACT_LVL);
endmodule

// File: rtl/sig_window_core.sv
module sig_window_core
    import sig_pkg::*;
#(
    parameter bit             START_RISE = 1'b1,
    parameter bit             STOP_RISE  = 1'b1,
    parameter logic [SIG_W-1:0] TAP_MASK = 16'h0291
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  probe_smp_t       smp,
    output logic             valid,
    output logic [SIG_W-1:0] sig,
    output logic             win_open,
    output logic [SIG_W-1:0] lfsr
);
    localparam logic START_ACT = START_RISE;
    localparam logic STOP_ACT  = STOP_RISE;

    typedef struct packed {
        logic             win_open;
        logic             prev_start;
        logic             prev_stop;
        logic [SIG_W-1:0] lfsr;
        logic             valid;
        logic [SIG_W-1:0] sig;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (strobe) begin
            if (!st_q.win_open && (smp.start != st_q.prev_start)) begin
                st_d.win_open = (smp.start == START_ACT);
            end else if (st_q.win_open && (smp.stop != st_q.prev_stop)
                         && (smp.stop == STOP_ACT)) begin
                st_d.win_open = 1'b0;
                st_d.valid    = 1'b1;
                st_d.sig      = st_q.lfsr;
                st_d.lfsr     = '0;
            end
            if (st_d.win_open) begin
                st_d.lfsr = {(^(st_q.lfsr & TAP_MASK)) ^ smp.data,
                             st_q.lfsr[SIG_W-1:1]};
            end
            st_d.prev_start = smp.start;
            st_d.prev_stop  = smp.stop;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q            <= '0;
            st_q.prev_start <= ~START_ACT;
            st_q.prev_stop  <= ~STOP_ACT;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid    = st_q.valid;
    assign sig      = st_q.sig;
    assign win_open = st_q.win_open;
    assign lfsr     = st_q.lfsr;
endmodule

// File: rtl/sig_symbol_enc.sv
module sig_symbol_enc
    import sig_pkg::*;
(
    input  logic [SIG_W-1:0] value,
    output logic [CHR_W-1:0] chars
);
    for (genvar g = 0; g < NIB_N; g++) begin : g_nib
        logic [3:0] rev_w;
        assign rev_w = {value[4*g], value[4*g+1], value[4*g+2], value[4*g+3]};
        assign chars[8*g +: 8] = sym_of(rev_w);
    end
endmodule

// File: rtl/sig_window_analyzer.sv
module sig_window_analyzer
    import sig_pkg::*;
#(
    parameter bit               START_RISE  = 1'b1,
    parameter bit               STOP_RISE   = 1'b1,
    parameter bit               CLK_FALL    = 1'b1,
    parameter int               SYNC_STAGES = 2,
    parameter logic [SIG_W-1:0] TAP_MASK    = 16'h0291
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             probe_start,
    input  logic             probe_stop,
    input  logic             probe_clk,
    input  logic             probe_data,
    output logic             sig_valid,
    output logic [SIG_W-1:0] sig_value,
    output logic [CHR_W-1:0] sig_chars
);
    logic [3:0]       sync_w;
    logic             strobe_w;
    probe_smp_t       smp_w;
    logic             win_open_w;
    logic [SIG_W-1:0] lfsr_w;

    sig_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  ({probe_clk, probe_start, probe_stop, probe_data}),
        .dout (sync_w)
    );

    assign smp_w = '{start: sync_w[2], stop: sync_w[1], data: sync_w[0]};

    sig_edge_strobe #(.ACT_FALL(CLK_FALL)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl    (sync_w[3]),
        .strobe (strobe_w)
    );

    sig_window_core #(
        .START_RISE (START_RISE),
        .STOP_RISE  (STOP_RISE),
        .TAP_MASK   (TAP_MASK)
    ) u_core (
        .clk      (clk),
        .rst      (rst),
        .strobe   (strobe_w),
        .smp      (smp_w),
        .valid    (sig_valid),
        .sig      (sig_value),
        .win_open (win_open_w),
        .lfsr     (lfsr_w)
    );

    sig_symbol_enc u_enc (
        .value (sig_value),
        .chars (sig_chars)
    );
endmodule

// File: rtl/sig_window_checker.sv
module sig_window_checker (
    input logic        clk,
    input logic        rst,
    input logic        sig_valid,
    input logic [15:0] sig_value,
    input logic [31:0] sig_chars,
    input logic        win_open,
    input logic [15:0] lfsr
);
    function automatic logic in_alpha(input logic [7:0] c);
        return (c >= 8'h30 && c <= 8'h39) || c == 8'h41 || c == 8'h43 ||
               c == 8'h46 || c == 8'h48 || c == 8'h50 || c == 8'h55;
    endfunction

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        sig_valid |=> !sig_valid);

    a_r7_closed_reg_zero: assert property (@(posedge clk) disable iff (rst)
        !win_open |-> (lfsr == 16'h0000));

    a_r4_valid_closes: assert property (@(posedge clk) disable iff (rst)
        sig_valid |-> (!win_open && lfsr == 16'h0000));

    a_r5_shift_right: assert property (@(posedge clk) disable iff (rst)
        (win_open && $past(win_open) && lfsr != $past(lfsr))
        |-> (lfsr[14:0] == $past(lfsr[15:1])));

    a_r11_reset_empty: assert property (@(posedge clk)
        rst |=> (!win_open && lfsr == 16'h0000 && !sig_valid));

    a_r8_alphabet: assert property (@(posedge clk) disable iff (rst)
        sig_valid |-> (in_alpha(sig_chars[7:0]) && in_alpha(sig_chars[15:8]) &&
                       in_alpha(sig_chars[23:16]) && in_alpha(sig_chars[31:24])));

    a_r8_one_symbol: assert property (@(posedge clk) disable iff (rst)
        (sig_valid && sig_value[3:0] == 4'h8) |-> (sig_chars[7:0] == 8'h31));
endmodule

bind sig_window_analyzer sig_window_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .sig_valid (sig_valid),
    .sig_value (sig_value),
    .sig_chars (sig_chars),
    .win_open  (win_open_w),
    .lfsr      (lfsr_w)
);

// File: tb/sig_window_analyzer_tb.sv
module sig_window_analyzer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        probe_start = 1'b0, probe_stop = 1'b0, probe_clk = 1'b1, probe_data = 1'b0;
    logic        sig_valid;
    logic [15:0] sig_value;
    logic [31:0] sig_chars;

    int checks = 0, errors = 0;
    int vcnt = 0;
    logic [15:0] vval;
    logic [31:0] vchars;

    // bench model state
    logic m_ps = 1'b0, m_pp = 1'b0, m_open = 1'b0;
    logic [15:0] m_reg = 16'h0;

    sig_window_analyzer dut_i (
        .clk(clk), .rst(rst), .probe_start(probe_start), .probe_stop(probe_stop),
        .probe_clk(probe_clk), .probe_data(probe_data),
        .sig_valid(sig_valid), .sig_value(sig_value), .sig_chars(sig_chars)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (sig_valid) begin
            vcnt++;
            vval   = sig_value;
            vchars = sig_chars;
        end
    end

    function automatic logic [31:0] exp_chars(input logic [15:0] v);
        string alpha = "0123456789ACFHPU";
        logic [31:0] r;
        for (int k = 0; k < 4; k++) begin
            logic [3:0] n;
            logic [3:0] rv;
            n = v[4*k +: 4];
            rv = {n[0], n[1], n[2], n[3]};
            r[8*k +: 8] = alpha[rv];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        m_ps = 1'b0; m_pp = 1'b0; m_open = 1'b0; m_reg = 16'h0;
        repeat (2) @(negedge clk);
    endtask

    // One probe clock period: falling edge samples, rising edge must be ignored.
    task automatic step(input logic s, input logic p, input logic d,
                        input bit glitch, input string tag,
                        output logic emit, output logic [15:0] val);
        vcnt = 0;
        probe_start = s; probe_stop = p; probe_data = d;
        repeat (4) @(negedge clk);
        probe_clk = 1'b0;
        repeat (5) @(negedge clk);
        if (glitch) begin
            probe_stop = ~p;
            repeat (3) @(negedge clk);
        end
        probe_clk = 1'b1;
        repeat (3) @(negedge clk);
        if (glitch) probe_stop = p;
        repeat (5) @(negedge clk);
        // model
        emit = 1'b0; val = 16'h0;
        if (!m_open && s != m_ps) begin
            m_open = s;
        end else if (m_open && p != m_pp) begin
            if (p) begin
                m_open = 1'b0; emit = 1'b1; val = m_reg; m_reg = 16'h0;
            end
        end
        if (m_open) m_reg = {(^(m_reg & 16'h0291)) ^ d, m_reg[15:1]};
        m_ps = s; m_pp = p;
        if (emit) begin
            chk(vcnt == 1, "R10", "valid pulse count", vcnt, 1);
            chk(vval == val, tag, "signature", vval, val);
            chk(vchars == exp_chars(val), "R8", "symbols", vchars, exp_chars(val));
        end else begin
            chk(vcnt == 0, tag, "unexpected valid", vcnt, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        finish_sim();
    end

    initial begin
        logic e;
        logic [15:0] v;
        void'($urandom(32'd2024));
        do_reset();
        chk(sig_valid == 1'b0, "R11", "valid after reset", sig_valid, 0);

        // R9 / R6 / R5: start high on first probe clock opens and shifts
        step(1, 0, 1, 0, "R9", e, v);
        step(1, 0, 0, 0, "R5", e, v);
        step(1, 1, 1, 0, "R4", e, v);
        chk(e && v == 16'h4000, "R6", "model first window", v, 16'h4000);
        chk(vval == 16'h4000, "R9", "first-clock open signature", vval, 16'h4000);
        chk(vchars == 32'h32303030, "R8", "chars of 0x4000", vchars, 32'h32303030);

        // R3: stop activity while closed yields nothing
        step(1, 0, 1, 0, "R3", e, v);
        step(1, 1, 1, 0, "R3", e, v);
        step(0, 0, 0, 0, "R3", e, v);
        // R2: open, then start toggle while open ignored
        step(1, 0, 1, 0, "R2", e, v);
        step(0, 0, 1, 0, "R3", e, v);
        step(1, 0, 0, 0, "R3", e, v);
        // R1: stop pulse around rising probe edge only
        step(1, 0, 1, 1, "R1", e, v);
        step(1, 0, 1, 0, "R1", e, v);
        // R7: close, then a second window starts from zero
        step(1, 1, 0, 0, "R7", e, v);
        step(0, 1, 0, 0, "R7", e, v);
        step(1, 0, 1, 0, "R7", e, v);
        step(1, 1, 0, 0, "R7", e, v);
        chk(vval == 16'h8000, "R7", "fresh window signature", vval, 16'h8000);

        // R11: reset in the middle of a window
        step(0, 0, 0, 0, "R11", e, v);
        step(1, 0, 1, 0, "R11", e, v);
        step(1, 0, 1, 0, "R11", e, v);
        do_reset();
        step(1, 1, 1, 0, "R11", e, v);
        chk(e == 1'b0, "R11", "model no signature after reset", e, 0);

        // random phase
        for (int i = 0; i < 400; i++) begin
            logic s, p, d, g;
            s = probe_start; p = probe_stop;
            if ($urandom_range(0, 7) == 0) s = ~s;
            if ($urandom_range(0, 5) == 0) p = ~p;
            d = $urandom_range(0, 1);
            g = ($urandom_range(0, 15) == 0);
            step(s, p, d, g, "R5", e, v);
        end
        finish_sim();
    end
endmodule